// File: doc/BRIEF.md
# Immediate Shift and Bitfield Execute Unit

This unit executes the one-register operations of a 32-bit integer core that carry a 5-bit immediate field. It reads one source register and the current carry flag, and returns a result with its write-enable, the next value of the carry flag, and three side flags. Those flags hand an unsigned or signed divide to a divider that lives elsewhere, or report an encoding the unit refuses to execute.

The operations fall into three groups. The first is shifts and a rotate by the immediate, where an immediate of zero turns each one into a single-bit shift that moves a bit through carry. The second is bit clear, set and test, plus low-mask and single-bit generation, each with reserved immediates. The third is add, subtract, reverse subtract, AND and two compares against the immediate. Add, subtract and less-than use the immediate plus one as the operand. One operation is accepted per cycle when `in_valid` is high, and every output is registered, so results arrive one cycle later.

Top module: `ishu_top`

## Requirements
- R1: Rotate-left (op 11) with a nonzero immediate n writes (x << n) | (x >> (32-n)) and leaves C unchanged. With n = 0 it writes {C, x[31:1]} and sets C to x[0].
- R2: Arithmetic right (op 12), logical left (op 13) and logical right (op 14) with an immediate of 0 shift by one and write the bit shifted out (x[0] for right shifts, x[31] for left) to C.
- R3: The shifts of R2 with a nonzero immediate n shift by n and leave C unchanged. Every writing operation except a zero-immediate shift or rotate leaves C equal to the input carry.
- R4: Add-immediate (op 0) writes x + imm + 1 and subtract-immediate (op 2) writes x - (imm + 1), both modulo 2^32.
- R5: Compare-below (op 1) sets C = (x < imm + 1), compared unsigned, and writes no result.
- R6: Compare-unequal (op 4) sets C = (x != imm), with no bias, and writes no result.
- R7: Bit-clear (op 7) and bit-set (op 9) write x with bit imm cleared or set. Bit-test (op 10) copies x[imm] into C and writes no result.
- R8: Low-mask (op 5) writes all ones for imm 0 and (1 << imm) - 1 for imm >= 8. Imm 1 raises the unsigned-divide flag, and imm 2 to 7 raise the illegal flag.
- R9: Bit-generate (op 8) writes 1 << imm for imm >= 7. Imm 1 raises the signed-divide flag, and imm 0 and 2 to 6 raise the illegal flag.
- R10: AND-immediate (op 6) writes x & imm and reverse-subtract-immediate (op 3) writes imm - x, where imm is zero-extended.
- R11: Op 15 raises the illegal flag. Whenever a divide or illegal flag is raised, no result is written and C keeps the input carry. At most one of the three flags is high.
- R12: Outputs for an operation accepted on one rising edge appear after that edge. A cycle with `in_valid` low yields `out_valid`, `out_we` and all three flags low.
- R13: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_imm | input | 5 | Immediate field |
| in_src | input | 32 | Source register value |
| in_c | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered copy of in_valid |
| out_res | output | 32 | Result to write back |
| out_we | output | 1 | Result write-enable |
| out_c | output | 1 | Next value of the carry flag |
| out_divu | output | 1 | Request for an unsigned divide |
| out_divs | output | 1 | Request for a signed divide |
| out_ill | output | 1 | Illegal encoding |

## Verification
Every result, including the carry and the three request flags, is due exactly one rising edge after the operation is presented, because the datapath is combinational into a single output register. The bench drives each operation on a falling edge and compares all outputs with its behavioural model on the next falling edge. This keeps every sample half a period away from the edge that loads the register. Idle cycles are mixed in and checked the same way, so a result that arrives late or is held too long shows up as a mismatch.

// File: rtl/ishu_pkg.sv
package ishu_pkg;

  typedef enum logic [3:0] {
    OP_ADDI   = 4'd0,
    OP_CMPLTI = 4'd1,
    OP_SUBI   = 4'd2,
    OP_RSUBI  = 4'd3,
    OP_CMPNEI = 4'd4,
    OP_MASKI  = 4'd5,
    OP_ANDI   = 4'd6,
    OP_BCLRI  = 4'd7,
    OP_GENI   = 4'd8,
    OP_BSETI  = 4'd9,
    OP_BTSTI  = 4'd10,
    OP_ROTLI  = 4'd11,
    OP_ASRI   = 4'd12,
    OP_LSLI   = 4'd13,
    OP_LSRI   = 4'd14,
    OP_RSVD   = 4'd15
  } imm_op_e;

  localparam int OP_W = 4;

endpackage

// File: rtl/ishu_shift.sv
module ishu_shift
  import ishu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  imm_op_e         op,
  input  logic [IW-1:0]   imm,
  input  logic [W-1:0]    src,
  input  logic            cin,
  output logic            hit,
  output logic            zero_form,
  output logic [W-1:0]    res,
  output logic            cout
);

  function automatic logic [W-1:0] rot_left(input logic [W-1:0] x, input logic [IW-1:0] n);
    logic [2*W-1:0] t;
    t = {x, x} << n;
    return t[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] sh_arith_r(input logic [W-1:0] x, input logic [IW-1:0] n);
    return W'($signed(x) >>> n);
  endfunction

  logic [IW-1:0] amt;

  assign hit       = (op == OP_ROTLI) || (op == OP_ASRI) || (op == OP_LSLI) || (op == OP_LSRI);
  assign zero_form = (imm == '0);
  assign amt       = zero_form ? IW'(1) : imm;

  always_comb begin
    res  = src;
    cout = cin;
    unique case (op)
      OP_ROTLI: begin
        if (zero_form) begin
          res  = {cin, src[W-1:1]};
          cout = src[0];
        end else begin
          res = rot_left(src, imm);
        end
      end
      OP_ASRI: begin
        res = sh_arith_r(src, amt);
        if (zero_form) cout = src[0];
      end
      OP_LSLI: begin
        res = src << amt;
        if (zero_form) cout = src[W-1];
      end
      OP_LSRI: begin
        res = src >> amt;
        if (zero_form) cout = src[0];
      end
      default: begin
        res  = src;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/ishu_arith.sv
module ishu_arith
  import ishu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  imm_op_e         op,
  input  logic [IW-1:0]   imm,
  input  logic [W-1:0]    src,
  input  logic            cin,
  output logic            hit,
  output logic            we,
  output logic [W-1:0]    res,
  output logic            cout
);

  function automatic logic [W-1:0] biased(input logic [IW-1:0] n);
    return W'(n) + W'(1);
  endfunction

  function automatic logic below_biased(input logic [W-1:0] x, input logic [IW-1:0] n);
    return x < biased(n);
  endfunction

  logic [W-1:0] imm_x;
  assign imm_x = W'(imm);

  assign hit = (op == OP_ADDI) || (op == OP_CMPLTI) || (op == OP_SUBI) ||
               (op == OP_RSUBI) || (op == OP_CMPNEI) || (op == OP_ANDI);

  always_comb begin
    res  = src;
    we   = 1'b0;
    cout = cin;
    unique case (op)
      OP_ADDI:   begin res = src + biased(imm); we = 1'b1; end
      OP_SUBI:   begin res = src - biased(imm); we = 1'b1; end
      OP_RSUBI:  begin res = imm_x - src;       we = 1'b1; end
      OP_ANDI:   begin res = src & imm_x;       we = 1'b1; end
      OP_CMPLTI: cout = below_biased(src, imm);
      OP_CMPNEI: cout = (src != imm_x);
      default:   begin res = src; we = 1'b0; end
    endcase
  end

endmodule

// File: rtl/ishu_bits.sv
module ishu_bits
  import ishu_pkg::*;
#(
  parameter int W        = 32,
  parameter int IW       = $clog2(W),
  parameter int MASK_MIN = 8,
  parameter int GEN_MIN  = 7
) (
  input  imm_op_e         op,
  input  logic [IW-1:0]   imm,
  input  logic [W-1:0]    src,
  input  logic            cin,
  output logic            hit,
  output logic            we,
  output logic [W-1:0]    res,
  output logic            cout,
  output logic            divu,
  output logic            divs,
  output logic            ill
);

  logic [W-1:0] sel_bit;

  for (genvar i = 0; i < W; i++) begin : g_sel
    assign sel_bit[i] = (imm == IW'(i));
  end

  function automatic logic [W-1:0] low_mask(input logic [W-1:0] onehot);
    return onehot - W'(1);
  endfunction

  logic imm_one;
  logic mask_ok;
  logic gen_ok;

  assign imm_one = (imm == IW'(1));
  assign mask_ok = (imm == '0) || (imm >= IW'(MASK_MIN));
  assign gen_ok  = (imm >= IW'(GEN_MIN));

  assign hit = (op == OP_MASKI) || (op == OP_BCLRI) || (op == OP_GENI) ||
               (op == OP_BSETI) || (op == OP_BTSTI);

  always_comb begin
    res  = src;
    we   = 1'b0;
    cout = cin;
    divu = 1'b0;
    divs = 1'b0;
    ill  = 1'b0;
    unique case (op)
      OP_BCLRI: begin res = src & ~sel_bit; we = 1'b1; end
      OP_BSETI: begin res = src | sel_bit;  we = 1'b1; end
      OP_BTSTI: cout = |(src & sel_bit);
      OP_MASKI: begin
        if (mask_ok) begin
          res = (imm == '0) ? '1 : low_mask(sel_bit);
          we  = 1'b1;
        end else if (imm_one) begin
          divu = 1'b1;
        end else begin
          ill = 1'b1;
        end
      end
      OP_GENI: begin
        if (gen_ok) begin
          res = sel_bit;
          we  = 1'b1;
        end else if (imm_one) begin
          divs = 1'b1;
        end else begin
          ill = 1'b1;
        end
      end
      default: begin res = src; we = 1'b0; end
    endcase
  end

endmodule

// File: rtl/ishu_top.sv
module ishu_top
  import ishu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MASK_MIN = 8,
  parameter int GEN_MIN  = 7,
  localparam int IW      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [IW-1:0]     in_imm,
  input  logic [DATA_W-1:0] in_src,
  input  logic              in_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_res,
  output logic              out_we,
  output logic              out_c,
  output logic              out_divu,
  output logic              out_divs,
  output logic              out_ill
);

  imm_op_e op;
  assign op = imm_op_e'(in_op);

  logic              sh_hit, sh_zero, sh_c;
  logic [DATA_W-1:0] sh_res;
  logic              ar_hit, ar_we, ar_c;
  logic [DATA_W-1:0] ar_res;
  logic              bt_hit, bt_we, bt_c, bt_divu, bt_divs, bt_ill;
  logic [DATA_W-1:0] bt_res;

  ishu_shift #(.W(DATA_W), .IW(IW)) u_shift (
    .op(op), .imm(in_imm), .src(in_src), .cin(in_c),
    .hit(sh_hit), .zero_form(sh_zero), .res(sh_res), .cout(sh_c)
  );

  ishu_arith #(.W(DATA_W), .IW(IW)) u_arith (
    .op(op), .imm(in_imm), .src(in_src), .cin(in_c),
    .hit(ar_hit), .we(ar_we), .res(ar_res), .cout(ar_c)
  );

  ishu_bits #(.W(DATA_W), .IW(IW), .MASK_MIN(MASK_MIN), .GEN_MIN(GEN_MIN)) u_bits (
    .op(op), .imm(in_imm), .src(in_src), .cin(in_c),
    .hit(bt_hit), .we(bt_we), .res(bt_res), .cout(bt_c),
    .divu(bt_divu), .divs(bt_divs), .ill(bt_ill)
  );

  logic [DATA_W-1:0] nxt_res;
  logic              nxt_we, nxt_c, nxt_divu, nxt_divs, nxt_ill;
  logic              nxt_req;

  always_comb begin
    nxt_res  = in_src;
    nxt_we   = 1'b0;
    nxt_c    = in_c;
    nxt_divu = 1'b0;
    nxt_divs = 1'b0;
    nxt_ill  = 1'b0;
    if (sh_hit) begin
      nxt_res = sh_res;
      nxt_we  = 1'b1;
      nxt_c   = sh_c;
    end else if (ar_hit) begin
      nxt_res = ar_res;
      nxt_we  = ar_we;
      nxt_c   = ar_c;
    end else if (bt_hit) begin
      nxt_res  = bt_res;
      nxt_we   = bt_we;
      nxt_c    = bt_c;
      nxt_divu = bt_divu;
      nxt_divs = bt_divs;
      nxt_ill  = bt_ill;
    end else begin
      nxt_ill  = 1'b1;
    end
  end

  assign nxt_req = nxt_divu || nxt_divs || nxt_ill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_we    <= 1'b0;
      out_c     <= 1'b0;
      out_divu  <= 1'b0;
      out_divs  <= 1'b0;
      out_ill   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res  <= nxt_res;
        out_we   <= nxt_we;
        out_c    <= nxt_c;
        out_divu <= nxt_divu;
        out_divs <= nxt_divs;
        out_ill  <= nxt_ill;
      end else begin
        out_we   <= 1'b0;
        out_divu <= 1'b0;
        out_divs <= 1'b0;
        out_ill  <= 1'b0;
      end
    end
  end

  // R11: a request or refusal never writes a result
  a_r11_req_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_divu || out_divs || out_ill) |-> !out_we);

  // R11: a request or refusal keeps the carry
  a_r11_req_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nxt_req |=> out_c == $past(in_c));

  // R11: flags are mutually exclusive
  a_r11_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_divu, out_divs, out_ill}));

  // R3: nonzero-immediate shifts keep the carry
  a_r3_nz_shift_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sh_hit && !sh_zero |=> out_c == $past(in_c));

  // R1: zero-immediate rotate moves a bit through carry
  a_r1_rot_through_c: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_ROTLI) && sh_zero |=>
      (out_res == {$past(in_c), $past(in_src[DATA_W-1:1])}) && (out_c == $past(in_src[0])));

  // R7: bit-test never writes
  a_r7_btst_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_BTSTI) |=> !out_we);

  // R12: an idle cycle produces no output activity
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_we && !out_divu && !out_divs && !out_ill);

endmodule

// File: tb/ishu_top_bench.sv
module ishu_top_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [4:0]  in_imm;
  logic [31:0] in_src;
  logic        in_c;
  logic        out_valid, out_we, out_c, out_divu, out_divs, out_ill;
  logic [31:0] out_res;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  ishu_top u_ishu_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_imm(in_imm), .in_src(in_src), .in_c(in_c), .out_valid(out_valid),
    .out_res(out_res), .out_we(out_we), .out_c(out_c), .out_divu(out_divu),
    .out_divs(out_divs), .out_ill(out_ill)
  );

  // Behavioural reference: bit loops instead of shifters
  task automatic model(input int op, input int imm, input logic [31:0] x, input logic c,
                       output logic [31:0] r, output logic we, output logic co,
                       output logic du, output logic ds, output logic il, output string req);
    r = 0; we = 0; co = c; du = 0; ds = 0; il = 0; req = "R11";
    case (op)
      0:  begin r = x + 32'(imm) + 32'd1; we = 1; req = "R4"; end
      2:  begin r = x - 32'(imm + 1);     we = 1; req = "R4"; end
      1:  begin co = (x < 32'(imm + 1));  req = "R5"; end
      4:  begin co = (x != 32'(imm));     req = "R6"; end
      3:  begin r = 32'(imm) - x; we = 1; req = "R10"; end
      6:  begin r = x & 32'(imm); we = 1; req = "R10"; end
      7:  begin r = x; r[imm] = 1'b0; we = 1; req = "R7"; end
      9:  begin r = x; r[imm] = 1'b1; we = 1; req = "R7"; end
      10: begin co = x[imm]; req = "R7"; end
      5: begin
        req = "R8";
        if (imm == 1) du = 1;
        else if (imm >= 2 && imm <= 7) il = 1;
        else begin
          for (int i = 0; i < 32; i++) if (imm == 0 || i < imm) r[i] = 1'b1;
          we = 1;
        end
      end
      8: begin
        req = "R9";
        if (imm == 1) ds = 1;
        else if (imm >= 7) begin r[imm] = 1'b1; we = 1; end
        else il = 1;
      end
      11: begin
        we = 1; req = "R1";
        if (imm == 0) begin r = {c, x[31:1]}; co = x[0]; end
        else begin r = x; for (int i = 0; i < imm; i++) r = {r[30:0], r[31]}; end
      end
      12, 13, 14: begin
        int n;
        we = 1;
        n = (imm == 0) ? 1 : imm;
        req = (imm == 0) ? "R2" : "R3";
        r = x;
        for (int i = 0; i < n; i++) begin
          if (op == 12) r = {r[31], r[31:1]};
          else if (op == 13) r = {r[30:0], 1'b0};
          else r = {1'b0, r[31:1]};
        end
        if (imm == 0) co = (op == 13) ? x[31] : x[0];
      end
      default: begin il = 1; req = "R11"; end
    endcase
  endtask

  // Drive on a falling edge, check on the next falling edge (R12 one-cycle latency)
  task automatic run(input int op, input int imm, input logic [31:0] x, input logic c);
    logic [31:0] er; logic ewe, ec, edu, eds, eil; string req;
    model(op, imm, x, c, er, ewe, ec, edu, eds, eil, req);
    in_valid = 1; in_op = 4'(op); in_imm = 5'(imm); in_src = x; in_c = c;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1 || out_we !== ewe || out_c !== ec || out_divu !== edu ||
        out_divs !== eds || out_ill !== eil || (ewe && out_res !== er)) begin
      errors++;
      $display("FAIL %s op=%0d imm=%0d src=%h c=%b: got v=%b we=%b c=%b du=%b ds=%b il=%b res=%h, exp v=1 we=%b c=%b du=%b ds=%b il=%b res=%h",
               req, op, imm, x, c, out_valid, out_we, out_c, out_divu, out_divs, out_ill,
               out_res, ewe, ec, edu, eds, eil, er);
    end
  endtask

  task automatic idle_check();
    in_valid = 0; in_op = 4'(0); in_src = 32'hFFFF_FFFF;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_divu !== 1'b0 ||
        out_divs !== 1'b0 || out_ill !== 1'b0) begin
      errors++;
      $display("FAIL R12 idle: got v=%b we=%b du=%b ds=%b il=%b, exp all 0",
               out_valid, out_we, out_divu, out_divs, out_ill);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got no completion, exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 1; in_op = 4'(0); in_imm = 5'(3); in_src = 32'h1234_5678; in_c = 1;
    repeat (3) @(negedge clk);
    checks++;  // R13 reset state
    if ({out_valid, out_we, out_c, out_divu, out_divs, out_ill} !== 6'b0 || out_res !== 32'h0) begin
      errors++;
      $display("FAIL R13 reset: got v=%b we=%b c=%b res=%h, exp zeros", out_valid, out_we, out_c, out_res);
    end
    rst_n = 1;
    idle_check();                      // R12
    // R1 rotate
    run(11, 0, 32'h8000_0001, 1'b0);
    run(11, 0, 32'h0000_0002, 1'b1);
    run(11, 4, 32'hF000_000F, 1'b1);
    run(11, 31, 32'h0000_0001, 1'b0);
    // R2 zero-immediate shifts
    run(12, 0, 32'h8000_0003, 1'b0);
    run(13, 0, 32'h8000_0000, 1'b0);
    run(14, 0, 32'h8000_0001, 1'b0);
    run(14, 0, 32'h0000_0002, 1'b1);
    // R3 nonzero shifts keep C
    run(12, 31, 32'h8000_0000, 1'b1);
    run(13, 5, 32'hFFFF_FFFF, 1'b0);
    run(14, 1, 32'h8000_0001, 1'b1);
    // R4 biased add/sub
    run(0, 0, 32'hFFFF_FFFF, 1'b1);
    run(0, 31, 32'h0000_0010, 1'b0);
    run(2, 0, 32'h0000_0000, 1'b1);
    run(2, 31, 32'h0000_0040, 1'b0);
    // R5 compare-below, boundaries at imm+1
    run(1, 4, 32'h0000_0004, 1'b0);
    run(1, 4, 32'h0000_0005, 1'b1);
    run(1, 31, 32'hFFFF_FFFF, 1'b1);
    // R6 compare-unequal
    run(4, 7, 32'h0000_0007, 1'b1);
    run(4, 7, 32'h0000_0008, 1'b0);
    // R7 bit ops
    run(7, 31, 32'hFFFF_FFFF, 1'b0);
    run(9, 0, 32'h0000_0000, 1'b1);
    run(10, 17, 32'h0002_0000, 1'b0);
    run(10, 17, 32'hFFFD_FFFF, 1'b1);
    // R8 mask, all immediates
    for (int i = 0; i < 32; i++) run(5, i, 32'hA5A5_A5A5, 1'b1);
    // R9 generate, all immediates
    for (int i = 0; i < 32; i++) run(8, i, 32'h5A5A_5A5A, 1'b0);
    // R10
    run(6, 21, 32'hFFFF_FFF0, 1'b0);
    run(3, 3, 32'h0000_0005, 1'b1);
    // R11 reserved op
    run(15, 9, 32'h1111_1111, 1'b1);
    idle_check();
    // mixed sweep
    for (int k = 0; k < 600; k++) begin
      run(int'($urandom_range(15, 0)), int'($urandom_range(31, 0)), $urandom, 1'($urandom));
      if (k % 37 == 0) idle_check();
    end
    done = 1;
    summary();
    $finish;
  end

endmodule